// File: doc/BRIEF.md
# Triggered Ring-Buffer Logic Analyzer

This block is an on-chip capture engine for debugging. It samples a wide vector of probe signals into a circular store. A programmable divider sets the sample rate. A one-bit trigger comparator watches one selected probe bit. The store keeps all history from before the trigger without a break. When the trigger fires, only a programmed number of further samples is taken, and then the capture freezes. This lets the trigger point sit anywhere in the window.

Host logic starts a capture with a one-cycle `arm_i` pulse. It then waits for the readout stream to become valid. The stream delivers the whole store once, oldest sample first, over a valid/ready handshake. Back-pressure is allowed at any time. While `rd_valid_o` is high and `rd_ready_i` is low, the sample and its `rd_last_o` flag are held unchanged. A sample counts as delivered only on a cycle where valid and ready are both high. The configuration inputs must stay stable from the arm pulse to the end of readout.

Top module: `trig_ring_analyzer`

## Requirements
- R1: After reset, `status_o` is 0 (idle) and `rd_valid_o` is low.
- R2: While capturing, a sample is taken every `cfg_div_i`+1 cycles. The first sample is taken at the first clock edge after the edge that accepted `arm_i`.
- R3: Trigger mode 0 (level) fires on a sample whose probe bit `cfg_sel_i` equals `cfg_level_i`.
- R4: Trigger mode 1 (rising) fires when the selected bit is 1 and was 0 in the previous sample. Mode 2 (falling) fires on the opposite change. Neither edge mode fires on the first sample after arming.
- R5: A trigger condition is ignored until at least DEPTH-1-`cfg_post_i` samples have been stored since arming.
- R6: After the trigger sample, exactly `cfg_post_i` more samples are taken. The readout stream becomes valid, with `status_o` = 3, at the edge that stores the last of them. While the post-trigger samples are being taken, `status_o` is 2.
- R7: `trig_addr_o` gives the store address of the trigger sample. That address is the number of samples taken since arming before the trigger sample, modulo DEPTH.
- R8: Readout delivers exactly DEPTH samples, oldest first. These are the final DEPTH samples taken. `rd_last_o` is high on the last one. After that last one is accepted, `status_o` returns to 0 and `rd_valid_o` goes low.
- R9: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_valid_o`, `rd_data_o` and `rd_last_o` hold steady.
- R10: `arm_i` restarts a capture from any state. This discards any readout in progress. On the next cycle, `status_o` is 1 (armed) and `rd_valid_o` is low.
- R11: Trigger mode 3 never fires. The analyzer stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | PROBE_W | Probe vector being sampled |
| arm_i | input | 1 | Start (or restart) a capture |
| cfg_div_i | input | DIV_W | Sample period minus one, in cycles |
| cfg_sel_i | input | SEL_W | Index of the probe bit that is watched |
| cfg_mode_i | input | 2 | 0 level, 1 rising, 2 falling, 3 off |
| cfg_level_i | input | 1 | Compare value for level mode |
| cfg_post_i | input | AW | Samples kept after the trigger sample |
| status_o | output | 2 | 0 idle, 1 armed, 2 post-trigger, 3 readout |
| trig_addr_o | output | AW | Store address of the trigger sample |
| rd_valid_o | output | 1 | Readout sample valid |
| rd_ready_i | input | 1 | Readout sample accepted |
| rd_data_o | output | PROBE_W | Readout sample |
| rd_last_o | output | 1 | Final sample of the readout |

## Verification
Take the cycle in which `arm_i` is held high as cycle a. Sample k then captures the probe value present in cycle a+1+k(`cfg_div_i`+1). Readout turns valid in the cycle after the edge that stores sample kt+`cfg_post_i`. The bench drives the probe as a known function of a free-running cycle count, so it can compute each sample value and the trigger index kt arithmetically. It then checks that `rd_valid_o` first appears at exactly that cycle. Readout and status are sampled just after the falling edge. A handshake is counted only when the bench's own ready and the design's valid were both high in that half-cycle.

// File: rtl/tra_pkg.sv
package tra_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } tra_state_e;

  typedef enum logic [1:0] {
    TM_LEVEL = 2'd0,
    TM_RISE  = 2'd1,
    TM_FALL  = 2'd2,
    TM_OFF   = 2'd3
  } tra_mode_e;
endpackage

// File: rtl/tra_rate_div.sv
module tra_rate_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         en,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (en) begin
      if (cnt_q == '0) cnt_q <= div;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tra_trig_match.sv
module tra_trig_match
  import tra_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic cur_bit,
  input  logic [1:0] mode,
  input  logic level,
  output logic hit
);
  logic prev_q;
  logic seen_q;

  always_comb begin
    unique case (tra_mode_e'(mode))
      TM_LEVEL: hit = (cur_bit == level);
      TM_RISE:  hit = seen_q && !prev_q && cur_bit;
      TM_FALL:  hit = seen_q && prev_q && !cur_bit;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (tick) begin
      prev_q <= cur_bit;
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tra_ring_store.sv
module tra_ring_store #(
  parameter int W  = 102,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trig_ring_analyzer.sv
module trig_ring_analyzer
  import tra_pkg::*;
#(
  parameter int PROBE_W = 102,
  parameter int AW      = 4,
  parameter int DIV_W   = 16,
  localparam int SEL_W  = $clog2(PROBE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               arm_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               cfg_level_i,
  input  logic [AW-1:0]      cfg_post_i,
  output logic [1:0]         status_o,
  output logic [AW-1:0]      trig_addr_o,
  output logic               rd_valid_o,
  input  logic               rd_ready_i,
  output logic [PROBE_W-1:0] rd_data_o,
  output logic               rd_last_o
);
  localparam int PAD_W = 1 << SEL_W;
  localparam logic [AW-1:0] TOP_IDX = {AW{1'b1}};

  tra_state_e    state_q;
  logic [AW-1:0] wr_ptr_q, fill_q, post_left_q, trig_addr_q, rd_ptr_q, rd_cnt_q;
  logic          capturing, tick, hit, fire, rd_fire;
  logic [AW-1:0] pre_need;
  logic [PAD_W-1:0] probe_pad;

  assign capturing = (state_q == ST_ARMED) || (state_q == ST_POST);
  assign probe_pad = PAD_W'(probe_i);
  assign pre_need  = TOP_IDX - cfg_post_i;

  tra_rate_div #(.W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .restart(arm_i), .en(capturing),
    .div(cfg_div_i), .tick(tick)
  );

  tra_trig_match i_match (
    .clk(clk), .rst_n(rst_n), .restart(arm_i), .tick(tick),
    .cur_bit(probe_pad[cfg_sel_i]), .mode(cfg_mode_i),
    .level(cfg_level_i), .hit(hit)
  );

  tra_ring_store #(.W(PROBE_W), .AW(AW)) i_store (
    .clk(clk), .we(tick), .waddr(wr_ptr_q), .wdata(probe_i),
    .raddr(rd_ptr_q), .rdata(rd_data_o)
  );

  assign fire    = tick && (state_q == ST_ARMED) && (fill_q >= pre_need) && hit;
  assign rd_fire = rd_valid_o && rd_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wr_ptr_q    <= '0;
      fill_q      <= '0;
      post_left_q <= '0;
      trig_addr_q <= '0;
      rd_ptr_q    <= '0;
      rd_cnt_q    <= '0;
    end else if (arm_i) begin
      state_q  <= ST_ARMED;
      wr_ptr_q <= '0;
      fill_q   <= '0;
      rd_cnt_q <= '0;
    end else begin
      if (tick) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
        if (fill_q != TOP_IDX) fill_q <= fill_q + 1'b1;
      end
      unique case (state_q)
        ST_ARMED: begin
          if (fire) begin
            trig_addr_q <= wr_ptr_q;
            post_left_q <= cfg_post_i;
            if (cfg_post_i == '0) begin
              state_q  <= ST_DONE;
              rd_ptr_q <= wr_ptr_q + 1'b1;
              rd_cnt_q <= '0;
            end else begin
              state_q <= ST_POST;
            end
          end
        end
        ST_POST: begin
          if (tick) begin
            post_left_q <= post_left_q - 1'b1;
            if (post_left_q == AW'(1)) begin
              state_q  <= ST_DONE;
              rd_ptr_q <= wr_ptr_q + 1'b1;
              rd_cnt_q <= '0;
            end
          end
        end
        ST_DONE: begin
          if (rd_fire) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
            rd_cnt_q <= rd_cnt_q + 1'b1;
            if (rd_cnt_q == TOP_IDX) state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign status_o    = state_q;
  assign trig_addr_o = trig_addr_q;
  assign rd_valid_o  = (state_q == ST_DONE);
  assign rd_last_o   = rd_valid_o && (rd_cnt_q == TOP_IDX);
endmodule

// File: rtl/tra_checker.sv
module tra_checker #(
  parameter int PROBE_W = 102
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm_i,
  input logic [1:0]         cfg_mode_i,
  input logic [1:0]         status_o,
  input logic               rd_valid_o,
  input logic               rd_ready_i,
  input logic [PROBE_W-1:0] rd_data_o,
  input logic               rd_last_o
);
  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !arm_i) |=>
      (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));

  a_r8_last_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_ready_i && rd_last_o && !arm_i) |=> (status_o == 2'd0));

  a_r10_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (status_o == 2'd1 && !rd_valid_o));

  a_r11_off_mode_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'd1 && cfg_mode_i == 2'd3 && !arm_i) |=> (status_o == 2'd1));

  a_r6_post_moves_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'd2 && !arm_i) |=> (status_o == 2'd2 || status_o == 2'd3));
endmodule

bind trig_ring_analyzer tra_checker #(.PROBE_W(PROBE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .cfg_mode_i(cfg_mode_i),
  .status_o(status_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_data_o(rd_data_o), .rd_last_o(rd_last_o)
);

// File: tb/test_trig_ring_analyzer.sv
module test_trig_ring_analyzer;
  localparam int PW = 8, AW = 3, DW = 3, DEPTH = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, arm = 1'b0, lvl = 1'b0, ready = 1'b0;
  logic [DW-1:0] div = '0;
  logic [2:0]    sel = '0;
  logic [1:0]    mode = '0, status;
  logic [AW-1:0] post = '0, taddr;
  logic [PW-1:0] probe, rdata;
  logic          rvalid, rlast;
  int cyc = 0, nvec = 0, nfail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PW-1:0] pat(input int c);
    int t;
    t = (c * 29) ^ (c >>> 2) ^ (c >>> 5);
    return t[PW-1:0];
  endfunction

  assign probe = pat(cyc);

  trig_ring_analyzer #(.PROBE_W(PW), .AW(AW), .DIV_W(DW)) i_trig_ring_analyzer (
    .clk(clk), .rst_n(rst_n), .probe_i(probe), .arm_i(arm), .cfg_div_i(div),
    .cfg_sel_i(sel), .cfg_mode_i(mode), .cfg_level_i(lvl), .cfg_post_i(post),
    .status_o(status), .trig_addr_o(taddr), .rd_valid_o(rvalid),
    .rd_ready_i(ready), .rd_data_o(rdata), .rd_last_o(rlast)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic sbit(input int c, input int b);
    logic [PW-1:0] v;
    v = pat(c);
    return v[b];
  endfunction

  // Reference trigger search (R3 R4 R5): returns the sample index of the trigger, or -1
  function automatic int find_kt(input int a, input int d, input int m, input int b,
                                 input logic lv, input int p);
    int pre = DEPTH - 1 - p;
    for (int k = 0; k < 200; k++) begin
      logic v, pv;
      v  = sbit(a + 1 + k * (d + 1), b);
      pv = (k > 0) ? sbit(a + 1 + (k - 1) * (d + 1), b) : 1'b0;
      if (k >= pre) begin
        if (m == 0 && v == lv) return k;
        if (m == 1 && k >= 1 && !pv && v) return k;
        if (m == 2 && k >= 1 && pv && !v) return k;
      end
    end
    return -1;
  endfunction

  task automatic run(input int m, input int b, input logic lv, input int p,
                     input int d, input bit bp, input int abort_at);
    int a, kt, exp_done, j, guard;
    @(negedge clk);
    mode = 2'(m); sel = 3'(b); lvl = lv; post = AW'(p); div = DW'(d);
    arm = 1'b1; a = cyc;
    @(negedge clk);
    arm = 1'b0;
    kt = find_kt(a, d, m, b, lv, p);
    if (kt < 0) begin
      repeat (64) @(negedge clk);
      chk(!rvalid && status == 2'd1, "R11", {rvalid, status}, 1);
      return;
    end
    exp_done = a + 2 + (kt + p) * (d + 1);
    while (!rvalid && cyc < exp_done + 5) @(negedge clk);
    chk(rvalid && cyc == exp_done, "R6", cyc, exp_done);
    chk(status == 2'd3, "R6", status, 3);
    chk(taddr == AW'(kt % DEPTH), (m == 0) ? "R3 R5 R7" : "R4 R5 R7", taddr, kt % DEPTH);
    j = 0; guard = 0;
    while (j < DEPTH && guard < 100) begin
      guard++;
      ready = bp ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (j == abort_at) begin
        ready = 1'b0; arm = 1'b1;
        @(negedge clk); arm = 1'b0; #1;
        chk(status == 2'd1 && !rvalid, "R10", {rvalid, status}, 1);
        return;
      end
      if (rvalid && ready) begin
        chk(rdata == pat(a + 1 + (kt + p - (DEPTH - 1) + j) * (d + 1)), "R2 R8",
            rdata, pat(a + 1 + (kt + p - (DEPTH - 1) + j) * (d + 1)));
        chk(rlast == (j == DEPTH - 1), "R8", rlast, j == DEPTH - 1);
        j++;
      end
      @(negedge clk);
    end
    ready = 1'b0; #1;
    chk(status == 2'd0 && !rvalid, "R8", {rvalid, status}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 2'd0 && !rvalid, "R1", {rvalid, status}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 2'd0 && !rvalid, "R1", {rvalid, status}, 0);
    for (int m = 0; m < 3; m++)
      for (int si = 0; si < 3; si++)
        for (int p = 0; p < DEPTH; p++)
          for (int d = 0; d < 4; d++)
            run(m, si * 3, logic'((p + d) & 1), p, d, bit'((m + si + p) & 1), -1);
    // R11: mode 3 never fires
    run(3, 2, 1'b1, 3, 1, 1'b0, -1);
    // R10: restart while armed, then while reading out
    run(0, 1, 1'b0, 2, 0, 1'b0, -1);
    run(1, 4, 1'b0, 5, 2, 1'b1, 3);
    run(2, 5, 1'b0, 1, 1, 1'b0, 0);
    run(0, 7, 1'b1, 7, 3, 1'b1, -1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule